// File: doc/BRIEF.md
# Serial Memory-Channel Bring-Up Sequencer

This block is the controller-side state machine that prepares a daisy chain of up to 32 memory devices after power-up or a system reset. All of its traffic goes over a slow serial control bus. It does not shift bits itself. It hands one transaction at a time to a serial transaction engine through a request port with a valid/acknowledge handshake. It waits for the acknowledge before it builds the next transaction.

A one-cycle `start_i` pulse latches the device count and starts the sequence. The first request is a broadcast serial-bus reset. Next comes a mandatory all-zero write to a guard test register, then the channel cycle time in units of 64 ps. After that, one pass gives every device its serial ID, ordered by position along the chain with the nearest device first. A second pass gives every device its memory ID. The memory ID comes from a host lookup port indexed by the serial ID, so devices of the same core configuration can be grouped. Six broadcast timing writes follow. The sequence ends with a broadcast set-reset command and a broadcast clear-reset command. `done_o` rises only after the clear-reset is acknowledged. An out-of-range device count raises `err_o` right after the serial reset is acknowledged.

Top module: `chan_bringup_seq`

## Requirements
- R1: While reset is asserted and after it is released, `req_valid_o`, `done_o` and `err_o` are 0.
- R2: The first request after an accepted start is the serial-bus reset. It has op code 1, broadcast flag 1, device 0, address 0 and data 0.
- R3: The second request is a broadcast write (op code 0) of data 0 to guard register address 0x0F0. No other write precedes it.
- R4: The third request is a broadcast write to address 0x0F1 carrying `cycle_time_i` zero-extended to 16 bits.
- R5: For a device count n, there follow n directed writes (broadcast 0) to address 0x0F2. The k-th write has device k and data k, for k = 0 up to n-1.
- R6: Next come n directed writes to address 0x0F3. The k-th write has device k and data equal to `mid_val_i` sampled while `mid_sel_o` = k.
- R7: Six broadcast writes follow, in this order: 0x0F4 with `pdx_a_i`, 0x0F5 with `pdx_b_i`, 0x0F6 with `nap_i`, 0x0F7 with `rlat_i`, 0x0F8 with `rdly_i`, 0x0F9 with `act_i`.
- R8: Two final broadcast requests follow: set-reset (op code 2), then clear-reset (op code 3), both with address 0 and data 0. `done_o` goes to 1 in the cycle after the clear-reset acknowledge. It stays at 1 until the next accepted start, which clears it.
- R9: Once `req_valid_o` is 1, it stays 1 with the request fields unchanged until the cycle in which `req_ack_i` is 1. No new request appears before that acknowledge.
- R10: A latched device count of 0 or greater than 32 sets `err_o` in the cycle after the serial-reset acknowledge. No further request is issued, and `done_o` stays 0. An accepted start clears `err_o`.
- R11: A `start_i` pulse while a sequence is running is ignored, and the request stream continues unchanged.
- R12: Device counts 1 and 32 are accepted and produce 13 and 75 requests respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dev_count_i | input | 6 | Number of devices in the chain, latched at start |
| cycle_time_i | input | 8 | Channel clock period in 64 ps units |
| pdx_a_i | input | 16 | First powerdown-exit timing value |
| pdx_b_i | input | 16 | Second powerdown-exit timing value |
| nap_i | input | 16 | Nap-exit timing value |
| rlat_i | input | 16 | Read-latency parameter (system minimum) |
| rdly_i | input | 16 | Read-latency delay (system minimum) |
| act_i | input | 16 | Activate-to-column parameter |
| mid_sel_o | output | 5 | Serial ID whose memory ID is being looked up |
| mid_val_i | input | 5 | Memory ID returned by the host lookup |
| req_valid_o | output | 1 | Request valid toward the transaction engine |
| req_op_o | output | 2 | 0 write, 1 serial reset, 2 set-reset, 3 clear-reset |
| req_bcast_o | output | 1 | Request addresses every device |
| req_dev_o | output | 5 | Target serial ID for directed requests |
| req_addr_o | output | 12 | Register address |
| req_data_o | output | 16 | Write data |
| req_ack_i | input | 1 | Engine acknowledge, completes the valid request |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Device count out of range |

## Verification
The bench goes after the ends of the per-device passes. A chain of one device exposes a design that leaves a pass one write late. A chain of 32 exposes a design whose index wraps or whose last-device test overflows. Counts of 0 and 33 must stop right after the serial reset, so a design that checks the count late, or with an off-by-one limit, would leak guard or ID writes onto the bus. The bench also holds acknowledges back for several cycles and sends a stray start in the middle of a run. A request that changed under an unacknowledged valid, or a sequence that restarted, would show up as a reordered or duplicated transaction stream.

// File: rtl/chan_bringup_pkg.sv
package chan_bringup_pkg;

    localparam int MAX_DEV = 32;
    localparam int ID_W    = $clog2(MAX_DEV);
    localparam int CNT_W   = ID_W + 1;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 16;
    localparam int CYC_W   = 8;

    typedef enum logic [1:0] {
        OP_WRITE        = 2'd0,
        OP_SERIAL_RESET = 2'd1,
        OP_SET_RESET    = 2'd2,
        OP_CLEAR_RESET  = 2'd3
    } op_e;

    // Ordered bring-up phases; the encoding order is the issue order.
    typedef enum logic [3:0] {
        PH_SRST  = 4'd0,
        PH_ZERO  = 4'd1,
        PH_CYCLE = 4'd2,
        PH_SID   = 4'd3,
        PH_MID   = 4'd4,
        PH_PDA   = 4'd5,
        PH_PDB   = 4'd6,
        PH_NAP   = 4'd7,
        PH_RLAT  = 4'd8,
        PH_RDLY  = 4'd9,
        PH_ACT   = 4'd10,
        PH_SET   = 4'd11,
        PH_CLR   = 4'd12
    } phase_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } state_e;

    typedef struct packed {
        op_e               op;
        logic              bcast;
        logic [ID_W-1:0]   dev;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    localparam logic [ADDR_W-1:0] A_GUARD = 12'h0F0;
    localparam logic [ADDR_W-1:0] A_CYCLE = 12'h0F1;
    localparam logic [ADDR_W-1:0] A_SID   = 12'h0F2;
    localparam logic [ADDR_W-1:0] A_MID   = 12'h0F3;
    localparam logic [ADDR_W-1:0] A_PDA   = 12'h0F4;
    localparam logic [ADDR_W-1:0] A_PDB   = 12'h0F5;
    localparam logic [ADDR_W-1:0] A_NAP   = 12'h0F6;
    localparam logic [ADDR_W-1:0] A_RLAT  = 12'h0F7;
    localparam logic [ADDR_W-1:0] A_RDLY  = 12'h0F8;
    localparam logic [ADDR_W-1:0] A_ACT   = 12'h0F9;

    function automatic logic [ADDR_W-1:0] phase_addr(input phase_e ph);
        case (ph)
            PH_ZERO:  return A_GUARD;
            PH_CYCLE: return A_CYCLE;
            PH_SID:   return A_SID;
            PH_MID:   return A_MID;
            PH_PDA:   return A_PDA;
            PH_PDB:   return A_PDB;
            PH_NAP:   return A_NAP;
            PH_RLAT:  return A_RLAT;
            PH_RDLY:  return A_RDLY;
            PH_ACT:   return A_ACT;
            default:  return '0;
        endcase
    endfunction

    function automatic op_e phase_op(input phase_e ph);
        case (ph)
            PH_SRST: return OP_SERIAL_RESET;
            PH_SET:  return OP_SET_RESET;
            PH_CLR:  return OP_CLEAR_RESET;
            default: return OP_WRITE;
        endcase
    endfunction

    function automatic logic per_device(input phase_e ph);
        return (ph == PH_SID) || (ph == PH_MID);
    endfunction

    function automatic phase_e next_phase(input phase_e ph);
        return phase_e'(4'(ph) + 4'd1);
    endfunction

    function automatic logic count_ok(input logic [CNT_W-1:0] n, input int limit);
        return (n != '0) && (int'(n) <= limit);
    endfunction

endpackage

// File: rtl/cbs_dev_iter.sv
module cbs_dev_iter
    import chan_bringup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [ID_W-1:0]  idx_o,
    output logic             last_o
);
    logic [ID_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = ({1'b0, idx_q} == (count_i - 1'b1));

endmodule

// File: rtl/cbs_payload_mux.sv
module cbs_payload_mux
    import chan_bringup_pkg::*;
(
    input  phase_e            phase_i,
    input  logic [ID_W-1:0]   idx_i,
    input  logic [CYC_W-1:0]  cycle_time_i,
    input  logic [DATA_W-1:0] pdx_a_i,
    input  logic [DATA_W-1:0] pdx_b_i,
    input  logic [DATA_W-1:0] nap_i,
    input  logic [DATA_W-1:0] rlat_i,
    input  logic [DATA_W-1:0] rdly_i,
    input  logic [DATA_W-1:0] act_i,
    input  logic [ID_W-1:0]   mid_val_i,
    output req_t              req_o
);
    always_comb begin
        req_o       = '0;
        req_o.op    = phase_op(phase_i);
        req_o.addr  = phase_addr(phase_i);
        req_o.bcast = !per_device(phase_i);
        req_o.dev   = per_device(phase_i) ? idx_i : '0;
        case (phase_i)
            PH_CYCLE: req_o.data = {{(DATA_W-CYC_W){1'b0}}, cycle_time_i};
            PH_SID:   req_o.data = {{(DATA_W-ID_W){1'b0}}, idx_i};
            PH_MID:   req_o.data = {{(DATA_W-ID_W){1'b0}}, mid_val_i};
            PH_PDA:   req_o.data = pdx_a_i;
            PH_PDB:   req_o.data = pdx_b_i;
            PH_NAP:   req_o.data = nap_i;
            PH_RLAT:  req_o.data = rlat_i;
            PH_RDLY:  req_o.data = rdly_i;
            PH_ACT:   req_o.data = act_i;
            default:  req_o.data = '0;
        endcase
    end

endmodule

// File: rtl/cbs_req_slot.sv
module cbs_req_slot
    import chan_bringup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  req_t req_i,
    input  logic ack_i,
    output logic valid_o,
    output req_t req_o,
    output logic xfer_o
);
    logic valid_q;
    req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            req_q   <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            req_q   <= req_i;
        end else if (valid_q && ack_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign req_o   = req_q;
    assign xfer_o  = valid_q && ack_i;

    // R9: an unacknowledged request keeps its contents
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ack_i) |=> (valid_q && $stable(req_q)));

    // R9: no new request is loaded over a pending one
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !valid_q);

endmodule

// File: rtl/chan_bringup_seq.sv
module chan_bringup_seq
    import chan_bringup_pkg::*;
#(
    parameter int DEV_LIMIT = MAX_DEV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  dev_count_i,
    input  logic [CYC_W-1:0]  cycle_time_i,
    input  logic [DATA_W-1:0] pdx_a_i,
    input  logic [DATA_W-1:0] pdx_b_i,
    input  logic [DATA_W-1:0] nap_i,
    input  logic [DATA_W-1:0] rlat_i,
    input  logic [DATA_W-1:0] rdly_i,
    input  logic [DATA_W-1:0] act_i,
    output logic [ID_W-1:0]   mid_sel_o,
    input  logic [ID_W-1:0]   mid_val_i,
    output logic              req_valid_o,
    output logic [1:0]        req_op_o,
    output logic              req_bcast_o,
    output logic [ID_W-1:0]   req_dev_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_data_o,
    input  logic              req_ack_i,
    output logic              done_o,
    output logic              err_o
);
    state_e           state_q;
    phase_e           phase_q;
    logic [CNT_W-1:0] count_q;
    logic             done_q, err_q, guard_seen_q;

    logic             accept, load, xfer, iter_clr, iter_adv, last_dev;
    logic [ID_W-1:0]  idx;
    req_t             next_req, cur_req;

    assign accept = (state_q == S_IDLE) && start_i;
    assign load   = (state_q == S_ISSUE);

    cbs_dev_iter u_iter (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (iter_clr),
        .adv_i   (iter_adv),
        .count_i (count_q),
        .idx_o   (idx),
        .last_o  (last_dev)
    );

    cbs_payload_mux u_mux (
        .phase_i      (phase_q),
        .idx_i        (idx),
        .cycle_time_i (cycle_time_i),
        .pdx_a_i      (pdx_a_i),
        .pdx_b_i      (pdx_b_i),
        .nap_i        (nap_i),
        .rlat_i       (rlat_i),
        .rdly_i       (rdly_i),
        .act_i        (act_i),
        .mid_val_i    (mid_val_i),
        .req_o        (next_req)
    );

    cbs_req_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .req_i   (next_req),
        .ack_i   (req_ack_i),
        .valid_o (req_valid_o),
        .req_o   (cur_req),
        .xfer_o  (xfer)
    );

    always_comb begin
        iter_clr = accept;
        iter_adv = 1'b0;
        if ((state_q == S_WAIT) && xfer && per_device(phase_q)) begin
            iter_clr = last_dev;
            iter_adv = !last_dev;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            phase_q      <= PH_SRST;
            count_q      <= '0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
            guard_seen_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        count_q      <= dev_count_i;
                        phase_q      <= PH_SRST;
                        done_q       <= 1'b0;
                        err_q        <= 1'b0;
                        guard_seen_q <= 1'b0;
                        state_q      <= S_ISSUE;
                    end
                end
                S_ISSUE: state_q <= S_WAIT;
                S_WAIT: begin
                    if (xfer) begin
                        if (phase_q == PH_ZERO) guard_seen_q <= 1'b1;
                        case (phase_q)
                            PH_SRST: begin
                                if (count_ok(count_q, DEV_LIMIT)) begin
                                    phase_q <= PH_ZERO;
                                    state_q <= S_ISSUE;
                                end else begin
                                    err_q   <= 1'b1;
                                    state_q <= S_IDLE;
                                end
                            end
                            PH_SID, PH_MID: begin
                                if (last_dev) phase_q <= next_phase(phase_q);
                                state_q <= S_ISSUE;
                            end
                            PH_CLR: begin
                                done_q  <= 1'b1;
                                state_q <= S_IDLE;
                            end
                            default: begin
                                phase_q <= next_phase(phase_q);
                                state_q <= S_ISSUE;
                            end
                        endcase
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign mid_sel_o   = idx;
    assign req_op_o    = cur_req.op;
    assign req_bcast_o = cur_req.bcast;
    assign req_dev_o   = cur_req.dev;
    assign req_addr_o  = cur_req.addr;
    assign req_data_o  = cur_req.data;
    assign done_o      = done_q;
    assign err_o       = err_q;

    // R8: completion follows the clear-reset acknowledge
    a_r8_done_after_clear: assert property (@(posedge clk) disable iff (rst)
        (xfer && phase_q == PH_CLR) |=> done_o);

    // R10: error and completion exclude each other
    a_r10_err_excl_done: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    // R10: nothing is requested while the error stands
    a_r10_quiet_on_err: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !req_valid_o);

    // R3: the first write of a run targets the guard register
    a_r3_guard_first: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_op_o == OP_WRITE && !guard_seen_q) |-> (req_addr_o == A_GUARD));

    // R5: per-device index never exceeds the latched chain length
    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE && per_device(phase_q)) |-> ({1'b0, idx} < count_q));

    // R11: a run in progress is not restarted
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && !xfer) |=> (state_q == S_WAIT));

endmodule

// File: tb/sim_chan_bringup_seq.sv
module sim_chan_bringup_seq;
    import chan_bringup_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [CNT_W-1:0]  dev_count;
    logic [CYC_W-1:0]  cyc;
    logic [DATA_W-1:0] pda, pdb, nap, rl, rd, act;
    logic [ID_W-1:0]   mid_sel, mid_val, mid_xor;
    logic              req_valid, req_bcast, ack, done, err;
    logic [1:0]        req_op;
    logic [ID_W-1:0]   req_dev;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    assign mid_val = mid_sel ^ mid_xor;

    chan_bringup_seq u0 (
        .clk(clk), .rst(rst), .start_i(start), .dev_count_i(dev_count),
        .cycle_time_i(cyc), .pdx_a_i(pda), .pdx_b_i(pdb), .nap_i(nap),
        .rlat_i(rl), .rdly_i(rd), .act_i(act), .mid_sel_o(mid_sel),
        .mid_val_i(mid_val), .req_valid_o(req_valid), .req_op_o(req_op),
        .req_bcast_o(req_bcast), .req_dev_o(req_dev), .req_addr_o(req_addr),
        .req_data_o(req_data), .req_ack_i(ack), .done_o(done), .err_o(err)
    );

    // stimulus/expectation table: count, ack latency, expected error
    localparam int TV_N = 6;
    localparam int TV_CNT [TV_N] = '{3, 1, 32, 0, 33, 5};
    localparam int TV_LAT [TV_N] = '{0, 2, 1, 0, 3, 4};
    localparam int TV_ERR [TV_N] = '{0, 0, 0, 1, 1, 0};

    logic [35:0] got [80];
    int ntx;

    task automatic check(input string rq, input logic [63:0] act_v, input logic [63:0] exp_v);
        tests++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act_v, exp_v);
        end
    endtask

    function automatic logic [35:0] mk(input int op, input int b, input int dv,
                                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        return {2'(op), 1'(b), 5'(dv), a, d};
    endfunction

    task automatic set_params(input int t);
        cyc     = 8'(20 + t);
        pda     = 16'h1100 + 16'(t);
        pdb     = 16'h2200 + 16'(t);
        nap     = 16'h3300 + 16'(t);
        rl      = 16'h0400 + 16'(t);
        rd      = 16'h0500 + 16'(t);
        act     = 16'h0600 + 16'(t);
        mid_xor = 5'(t * 7 + 3);
    endtask

    task automatic run_seq(input int n, input int lat, input bit poke);
        bit seen;
        int w;
        dev_count = 6'(n);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R8 done cleared by start", {63'd0, done}, 64'd0);
        check("R10 err cleared by start", {63'd0, err}, 64'd0);
        ntx = 0; seen = 0; w = 0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            ack = 1'b0;
            start = 1'b0;
            if (done || err) break;
            if (req_valid) begin
                if (!seen) begin
                    if (ntx < 80) got[ntx] = {req_op, req_bcast, req_dev, req_addr, req_data};
                    ntx++;
                    seen = 1; w = 0;
                    if (poke && ntx == 4) start = 1'b1;
                end else begin
                    check("R9 request stable until ack",
                          {28'd0, req_op, req_bcast, req_dev, req_addr, req_data},
                          {28'd0, got[ntx-1]});
                end
                if (w == lat) begin
                    ack = 1'b1; seen = 0;
                end else begin
                    w++;
                end
            end
        end
        ack = 1'b0;
    endtask

    task automatic check_stream(input int n, input string cnt_tag);
        logic [35:0] e;
        string tg;
        check(cnt_tag, 64'(ntx), 64'(11 + 2 * n));
        for (int i = 0; i < 11 + 2 * n && i < ntx && i < 80; i++) begin
            if (i == 0) begin
                e = mk(1, 1, 0, 12'h000, 16'h0000); tg = "R2 serial reset";
            end else if (i == 1) begin
                e = mk(0, 1, 0, 12'h0F0, 16'h0000); tg = "R3 guard zero write";
            end else if (i == 2) begin
                e = mk(0, 1, 0, 12'h0F1, {8'd0, cyc}); tg = "R4 cycle time";
            end else if (i < 3 + n) begin
                e = mk(0, 0, i - 3, 12'h0F2, 16'(i - 3)); tg = "R5 serial id";
            end else if (i < 3 + 2 * n) begin
                e = mk(0, 0, i - 3 - n, 12'h0F3, {11'd0, 5'(i - 3 - n) ^ mid_xor});
                tg = "R6 memory id";
            end else if (i < 9 + 2 * n) begin
                case (i - 3 - 2 * n)
                    0: e = mk(0, 1, 0, 12'h0F4, pda);
                    1: e = mk(0, 1, 0, 12'h0F5, pdb);
                    2: e = mk(0, 1, 0, 12'h0F6, nap);
                    3: e = mk(0, 1, 0, 12'h0F7, rl);
                    4: e = mk(0, 1, 0, 12'h0F8, rd);
                    default: e = mk(0, 1, 0, 12'h0F9, act);
                endcase
                tg = "R7 timing writes";
            end else if (i == 9 + 2 * n) begin
                e = mk(2, 1, 0, 12'h000, 16'h0000); tg = "R8 set-reset";
            end else begin
                e = mk(3, 1, 0, 12'h000, 16'h0000); tg = "R8 clear-reset";
            end
            check(tg, {28'd0, got[i]}, {28'd0, e});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; ack = 1'b0; dev_count = '0;
        set_params(0);
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'd0, req_valid}, 64'd0);
        check("R1 done in reset", {63'd0, done}, 64'd0);
        check("R1 err in reset", {63'd0, err}, 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", {61'd0, req_valid, done, err}, 64'd0);

        for (int t = 0; t < TV_N; t++) begin
            set_params(t);
            run_seq(TV_CNT[t], TV_LAT[t], 1'b0);
            if (TV_ERR[t] != 0) begin
                check("R10 only serial reset issued", 64'(ntx), 64'd1);
                check("R10 first request is serial reset", {28'd0, got[0]},
                      {28'd0, mk(1, 1, 0, 12'h000, 16'h0000)});
                check("R10 err set", {63'd0, err}, 64'd1);
                check("R10 done stays low", {63'd0, done}, 64'd0);
                for (int k = 0; k < 20; k++) begin
                    @(negedge clk);
                    if (req_valid) check("R10 no request after error", 64'd1, 64'd0);
                end
                check("R10 err held", {63'd0, err}, 64'd1);
            end else begin
                check_stream(TV_CNT[t], (TV_CNT[t] == 1 || TV_CNT[t] == 32)
                             ? "R12 boundary request count" : "R5 request count");
                check("R8 done raised", {63'd0, done}, 64'd1);
                check("R8 err low on success", {63'd0, err}, 64'd0);
                repeat (10) @(negedge clk);
                check("R8 done held until next start", {62'd0, done, req_valid}, 64'd2);
            end
        end

        // R11: stray start in the middle of a run
        set_params(9);
        run_seq(2, 1, 1'b1);
        check_stream(2, "R11 stray start ignored");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule